// File: doc/BRIEF.md
# Compact Two-Register Serial Port

This block is a full-duplex asynchronous serial port for a host bus that sees it as two 16-bit registers. The control/status word sits at address 0. It holds the transmit and receive flags, the clear-to-send input level, the request-to-send output, a three-bit rate selector and a nine-bit frame enable. Address 1 is the data window. A read there pops the oldest received character, and a write there queues one character for transmission.

There is no hardware parity. Software that needs even or odd parity computes the parity bit itself and sends it as the ninth data bit in nine-bit mode. The rate table has seven fixed speeds derived from one system clock. The eighth code of the selector turns the port off: both serial engines are held idle, the line rests high and the interrupt is masked.

There is one level interrupt. It is high while received data is waiting, and it is also set each time the transmitter finishes a frame. Any register read clears that transmit-finished event. Received characters pass through a small queue (five entries by default, one as an option), and an overrun flag reports characters that were lost because the queue was full.

Top module: `tiny_uart`

## Requirements
- R1: After reset the status word reads 0x00E9 when clear-to-send is high, with rate code 7, request-to-send low and nine-bit mode off. The interrupt is low and the serial output is high.
- R2: Rate codes 0..6 give bit times of 1, 2, 3, 6, 12, 24 and 48 units. A unit is 16 oversample ticks of BASE clocks each, so the defaults give 115200 down to 2400 baud at 14.7456 MHz.
- R3: With rate code 7 the serial output stays high and the interrupt stays low. Both engines are cleared, and writes to the data window are discarded.
- R4: A frame is a low start bit, the data bits sent least significant bit first, and one high stop bit. It carries 8 data bits, or 9 data bits when status bit 8 is set.
- R5: A new frame starts only while clear-to-send is high. A pending character waits for as long as that input is low.
- R6: Status bit 0 (transmit holding empty) is 1 whenever no character is waiting to be sent. It clears on a write to address 1 and sets again when the character moves into the shift register. A second write before that move replaces the waiting character.
- R7: The receiver samples each bit at mid-bit. A low pulse shorter than half a bit is ignored, and a character whose stop bit samples low is dropped.
- R8: Received characters are read from address 1 in arrival order, up to the queue depth. Status bit 1 is 1 while the queue is not empty.
- R9: A character that completes while the queue is full is discarded and sets status bit 2. That bit clears on a read of the status word.
- R10: While rate code is not 7 and status bit 1 is set, the interrupt is high.
- R11: When a frame finishes, the interrupt rises and stays high until the next read of either register.
- R12: Status bit 3 reads the clear-to-send input, and status bit 4 is read/write and drives request-to-send. In nine-bit mode, read-data bit 8 returns the ninth received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register access strobe, one cycle per access |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 1 | 0 = status/control, 1 = data window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while sel is high and wr_en is low |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| cts | input | 1 | Clear-to-send, high permits transmission |
| rts | output | 1 | Request-to-send, driven from status bit 4 |

## Verification
Several properties are checked on every cycle: the line stays high while the port is off, a frame never starts without clear-to-send, the holding register only fills from a host write, a full-queue arrival raises overrun, and a finished frame raises the interrupt. Other behaviour only shows up in the bench scenarios. These cover the exact bit timing of each rate, the order of the data bits, nine-bit framing, rejection of glitches and of bad stop bits, the order in which the queue hands back characters, the clearing of flags on reads, and the replacement of a waiting transmit character.

// File: rtl/tu_pkg.sv
package tu_pkg;
  localparam logic [2:0] MODE_OFF = 3'd7;

  // bit time in units of the fastest rate
  function automatic int unsigned rate_mult(input logic [2:0] m);
    case (m)
      3'd0:    rate_mult = 1;
      3'd1:    rate_mult = 2;
      3'd2:    rate_mult = 3;
      3'd3:    rate_mult = 6;
      3'd4:    rate_mult = 12;
      3'd5:    rate_mult = 24;
      default: rate_mult = 48;
    endcase
  endfunction

  // shift image, bit 0 leaves first
  function automatic logic [10:0] tx_frame(input logic [8:0] d, input logic nine);
    tx_frame = nine ? {1'b1, d, 1'b0} : {2'b11, d[7:0], 1'b0};
  endfunction

  function automatic logic [3:0] frame_bits(input logic nine);
    frame_bits = nine ? 4'd11 : 4'd10;
  endfunction
endpackage

// File: rtl/tu_tick.sv
module tu_tick #(
  parameter int BASE = 8,
  parameter int CW   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  output logic       tick
);
  import tu_pkg::*;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = CW'(BASE * rate_mult(mode) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (mode == MODE_OFF || cnt >= lim) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (mode != MODE_OFF) && (cnt >= lim);
endmodule

// File: rtl/tu_tx.sv
module tu_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       cts,
  input  logic       nine,
  input  logic       wr,
  input  logic [8:0] wdata,
  output logic       txd,
  output logic       thr_empty,
  output logic       busy,
  output logic       done
);
  import tu_pkg::*;
  localparam int PW = $clog2(OVS);

  logic          thr_full;
  logic [8:0]    thr;
  logic [10:0]   sh;
  logic [3:0]    left;
  logic [PW-1:0] ph;
  logic          act;
  logic          load;

  assign load = en && tick && !act && thr_full && cts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_full <= 1'b0;
      thr      <= '0;
      sh       <= '1;
      left     <= '0;
      ph       <= '0;
      act      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        thr_full <= 1'b0;
        act      <= 1'b0;
      end else begin
        if (load) begin
          sh       <= tx_frame(thr, nine);
          left     <= frame_bits(nine);
          ph       <= '0;
          act      <= 1'b1;
          thr_full <= 1'b0;
        end else if (act && tick) begin
          if (ph == PW'(OVS - 1)) begin
            ph   <= '0;
            sh   <= {1'b1, sh[10:1]};
            left <= left - 1'b1;
            if (left == 4'd1) begin
              act  <= 1'b0;
              done <= 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        if (wr) begin
          thr      <= wdata;
          thr_full <= 1'b1;
        end
      end
    end
  end

  assign txd       = act ? sh[0] : 1'b1;
  assign thr_empty = !thr_full;
  assign busy      = act;
endmodule

// File: rtl/tu_rx.sv
module tu_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       nine,
  input  logic       rxd,
  output logic       valid,
  output logic [8:0] data
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] MID = PW'(OVS / 2 - 1);

  typedef enum logic [1:0] {HUNT, START, DATA, STOP} rx_st_t;
  rx_st_t        st;
  logic          s1, s2;
  logic [PW-1:0] ph;
  logic [3:0]    idx;
  logic [8:0]    acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= HUNT;
      ph    <= '0;
      idx   <= '0;
      acc   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!en) begin
        st <= HUNT;
      end else if (tick) begin
        case (st)
          HUNT: if (!s2) begin
            st <= START;
            ph <= '0;
          end
          START: begin
            ph <= ph + 1'b1;
            if (ph == MID) begin
              if (s2) st <= HUNT;
              else begin
                st  <= DATA;
                idx <= '0;
                acc <= '0;
              end
            end
          end
          DATA: begin
            ph <= ph + 1'b1;
            if (ph == MID) begin
              acc[idx] <= s2;
              idx      <= idx + 1'b1;
              if (idx == 4'(nine ? 8 : 7)) st <= STOP;
            end
          end
          default: begin
            ph <= ph + 1'b1;
            if (ph == MID) begin
              st    <= HUNT;
              valid <= s2;
            end
          end
        endcase
      end
    end
  end

  assign data = acc;
endmodule

// File: rtl/tu_rxq.sv
module tu_rxq #(
  parameter int DEPTH = 5,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  assign drop = push && full;

  generate
    if (DEPTH == 1) begin : g_single
      logic         held;
      logic [W-1:0] hold;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          held <= 1'b0;
          hold <= '0;
        end else if (push && !held) begin
          held <= 1'b1;
          hold <= din;
        end else if (pop) begin
          held <= 1'b0;
        end
      end
      assign dout  = hold;
      assign empty = !held;
      assign full  = held;
    end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      logic [W-1:0]  mem [DEPTH];
      logic [AW-1:0] rp, wp;
      logic [CW-1:0] cnt;
      logic          do_push, do_pop;

      assign full    = (cnt == CW'(DEPTH));
      assign empty   = (cnt == '0);
      assign do_push = push && !full;
      assign do_pop  = pop && !empty;

      always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rp  <= '0;
          wp  <= '0;
          cnt <= '0;
        end else begin
          if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
          if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
          case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
          endcase
        end
      end
      assign dout = mem[rp];
    end
  endgenerate
endmodule

// File: rtl/tiny_uart.sv
module tiny_uart #(
  parameter int BASE      = 8,
  parameter int OVS       = 16,
  parameter int RXQ_DEPTH = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic        txd,
  input  logic        rxd,
  input  logic        cts,
  output logic        rts
);
  import tu_pkg::*;

  logic [2:0] mode;
  logic       nine, rts_q, ovr, txdone_f;
  logic       wr_stat, wr_tx, rd_stat, rd_data, any_rd;
  logic       mode_off, en, tick;
  logic       thr_empty, tx_busy, tx_done;
  logic       rx_valid;
  logic [8:0] rx_char, q_dout;
  logic       q_empty, q_full, q_drop;
  logic       unused_ok;

  assign wr_stat  = sel && wr_en && !addr;
  assign wr_tx    = sel && wr_en && addr;
  assign rd_stat  = sel && !wr_en && !addr;
  assign rd_data  = sel && !wr_en && addr;
  assign any_rd   = sel && !wr_en;
  assign mode_off = (mode == MODE_OFF);
  assign en       = !mode_off;
  assign unused_ok = ^wdata[15:9];

  tu_tick #(.BASE(BASE)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick)
  );

  tu_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .cts(cts), .nine(nine),
    .wr(wr_tx), .wdata(wdata[8:0]), .txd(txd), .thr_empty(thr_empty),
    .busy(tx_busy), .done(tx_done)
  );

  tu_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .nine(nine), .rxd(rxd),
    .valid(rx_valid), .data(rx_char)
  );

  tu_rxq #(.DEPTH(RXQ_DEPTH), .W(9)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_valid), .din(rx_char), .pop(rd_data),
    .dout(q_dout), .empty(q_empty), .full(q_full), .drop(q_drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_OFF;
      nine     <= 1'b0;
      rts_q    <= 1'b0;
      ovr      <= 1'b0;
      txdone_f <= 1'b0;
    end else begin
      if (wr_stat) begin
        rts_q <= wdata[4];
        mode  <= wdata[7:5];
        nine  <= wdata[8];
      end
      if (q_drop) ovr <= 1'b1;
      else if (rd_stat) ovr <= 1'b0;
      if (!en) txdone_f <= 1'b0;
      else if (tx_done) txdone_f <= 1'b1;
      else if (any_rd) txdone_f <= 1'b0;
    end
  end

  always_comb begin
    rdata = 16'h0000;
    if (any_rd) begin
      if (addr) rdata = {7'b0, q_dout};
      else      rdata = {7'b0, nine, mode, rts_q, cts, ovr, !q_empty, thr_empty};
    end
  end

  assign irq = en && (!q_empty || txdone_f);
  assign rts = rts_q;
endmodule

// File: rtl/tu_checker.sv
module tu_checker (
  input logic clk,
  input logic rst_n,
  input logic mode_off,
  input logic txd,
  input logic irq,
  input logic cts,
  input logic tx_busy,
  input logic tx_done,
  input logic thr_empty,
  input logic wr_tx,
  input logic rx_valid,
  input logic q_full,
  input logic ovr
);
  p_line_idle_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_off && $past(mode_off)) |-> txd);

  p_start_needs_cts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(cts));

  p_holding_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(thr_empty) |-> $past(wr_tx));

  p_overrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && q_full) |=> ovr);

  p_done_raises_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !mode_off) |=> (irq || mode_off));
endmodule

bind tiny_uart tu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_off(mode_off), .txd(txd), .irq(irq),
  .cts(cts), .tx_busy(tx_busy), .tx_done(tx_done), .thr_empty(thr_empty),
  .wr_tx(wr_tx), .rx_valid(rx_valid), .q_full(q_full), .ovr(ovr)
);

// File: tb/test_tiny_uart.sv
`timescale 1ns/1ps
module test_tiny_uart;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic rxd = 1'b1, cts = 1'b1;
  logic [15:0] rdata;
  logic irq, txd, rts;

  int checks = 0;
  int errors = 0;
  bit mon_off = 1'b0;

  tiny_uart #(.BASE(BASE)) i_tiny_uart (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .txd(txd), .rxd(rxd),
    .cts(cts), .rts(rts)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench view of the rate table: baud per code, clocks per bit
  function automatic int bit_clks(input int code);
    int baud;
    case (code)
      0: baud = 115200; 1: baud = 57600; 2: baud = 38400; 3: baud = 19200;
      4: baud = 9600;   5: baud = 4800;  default: baud = 2400;
    endcase
    return 16 * BASE * (115200 / baud);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle model: port off means idle line, quiet interrupt
  always @(negedge clk) begin
    if (rst_n && mon_off) begin
      checks++;
      if (txd !== 1'b1 || irq !== 1'b0) begin
        errors++;
        $display("FAIL R3 actual txd=%b irq=%b expected txd=1 irq=0", txd, irq);
      end
    end
  end

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic watch_line(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  task automatic get_serial(input int nbits, input int bc, output int val, output int ok);
    int t;
    val = 0; ok = 1; t = 0;
    while (txd !== 1'b0 && t < 20 * bc + 200) begin
      @(negedge clk);
      t++;
    end
    if (txd !== 1'b0) ok = 0;
    repeat (bc / 2) @(negedge clk);
    if (txd !== 1'b0) ok = 0;
    for (int i = 0; i < nbits; i++) begin
      repeat (bc) @(negedge clk);
      if (txd === 1'b1) val |= (1 << i);
    end
    repeat (bc) @(negedge clk);
    if (txd !== 1'b1) ok = 0;
  endtask

  task automatic send_serial(input int val, input int nbits, input int bc, input logic stopv);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxd = val[i];
      repeat (bc) @(negedge clk);
    end
    rxd = stopv;
    repeat (bc) @(negedge clk);
    rxd = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int v, ok, lows;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_off = 1'b1;

    // R1 reset state
    rd(1'b0, d);
    check("R1 status", d, 16'h00E9);
    check("R1 irq", irq, 0);
    check("R1 txd", txd, 1);

    // R3 data writes discarded while off
    wr(1'b1, 16'h0055);
    watch_line(200, lows);
    rd(1'b0, d);
    check("R3 status unchanged", d, 16'h00E9);

    // R12 rts and cts bits, rate 0
    mon_off = 1'b0;
    wr(1'b0, 16'h0010);
    rd(1'b0, d);
    check("R12 status rts", d, 16'h0019);
    check("R12 rts pin", rts, 1);
    cts = 1'b0;
    rd(1'b0, d);
    check("R12 status cts low", d, 16'h0011);

    // R5 hold while cts low; R6 holding flag
    wr(1'b1, 16'h00A5);
    watch_line(300, lows);
    check("R5 line idle while cts low", lows, 0);
    rd(1'b0, d);
    check("R6 holding full", d, 16'h0010);
    cts = 1'b1;
    get_serial(8, bit_clks(0), v, ok);
    check("R4 8-bit frame data", v, 8'hA5);
    check("R4 8-bit frame framing", ok, 1);
    repeat (bit_clks(0)) @(negedge clk);
    check("R11 irq after frame", irq, 1);
    rd(1'b1, d);
    check("R11 irq cleared by read", irq, 0);

    // R6 second write replaces waiting character
    cts = 1'b0;
    wr(1'b1, 16'h0011);
    wr(1'b1, 16'h0022);
    cts = 1'b1;
    get_serial(8, bit_clks(0), v, ok);
    check("R6 replaced character", v, 8'h22);
    watch_line(3 * bit_clks(0), lows);
    check("R6 no second frame", lows, 0);
    rd(1'b0, d);

    // R4 nine-bit frame at rate 2
    wr(1'b0, 16'h0150);
    wr(1'b1, 16'h01C3);
    get_serial(9, bit_clks(2), v, ok);
    check("R4 9-bit frame data", v, 9'h1C3);
    check("R4 9-bit framing", ok, 1);
    watch_line(2 * bit_clks(2), lows);
    rd(1'b0, d);

    // R2 slowest rate
    wr(1'b0, 16'h00C0);
    wr(1'b1, 16'h003C);
    get_serial(8, bit_clks(6), v, ok);
    check("R2 rate 6 data", v, 8'h3C);
    check("R2 rate 6 framing", ok, 1);
    watch_line(bit_clks(6), lows);
    rd(1'b0, d);

    // R7 R10 receive at rate 0
    wr(1'b0, 16'h0000);
    rd(1'b0, d);
    send_serial(8'h5A, 8, bit_clks(0), 1'b1);
    repeat (5) @(negedge clk);
    check("R10 irq on rx ready", irq, 1);
    rd(1'b0, d);
    check("R8 status rx ready", d, 16'h000B);
    rd(1'b1, d);
    check("R7 received data", d, 16'h005A);
    check("R10 irq drops when empty", irq, 0);

    // R7 glitch and bad stop
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (300) @(negedge clk);
    rd(1'b0, d);
    check("R7 glitch ignored", d, 16'h0009);
    send_serial(8'h33, 8, bit_clks(0), 1'b0);
    repeat (40) @(negedge clk);
    rd(1'b0, d);
    check("R7 bad stop dropped", d, 16'h0009);

    // R8 R9 queue order and overrun
    for (int k = 0; k < 6; k++) send_serial(8'h10 + k, 8, bit_clks(0), 1'b1);
    repeat (5) @(negedge clk);
    rd(1'b0, d);
    check("R9 overrun set", d, 16'h000F);
    rd(1'b0, d);
    check("R9 overrun cleared by status read", d, 16'h000B);
    for (int k = 0; k < 5; k++) begin
      rd(1'b1, d);
      check("R8 queue order", d, 8'h10 + k);
    end
    rd(1'b0, d);
    check("R8 queue empty", d, 16'h0009);

    // R12 nine-bit receive
    wr(1'b0, 16'h0100);
    send_serial(9'h1A7, 9, bit_clks(0), 1'b1);
    repeat (5) @(negedge clk);
    rd(1'b1, d);
    check("R12 ninth bit received", d, 16'h01A7);

    // R3 back off
    wr(1'b0, 16'h00E0);
    @(negedge clk);
    mon_off = 1'b1;
    send_serial(8'h77, 8, bit_clks(0), 1'b1);
    repeat (50) @(negedge clk);
    rd(1'b0, d);
    check("R3 receiver idle while off", d, 16'h00E9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule